// File: doc/BRIEF.md
# Condition Flag and Branch Decision Unit

This unit sits beside an integer datapath and keeps the four condition flags: zero (Z), negative (N), carry (C) and overflow (V). Each cycle the datapath presents the two operands, the result it produced, the operation class and the operand size, either byte or word. When the update strobe is high, the unit works out the new flags with the rule for that class and stores them on the next rising clock edge. Classes that leave a flag alone keep its stored value.

In the same cycle the unit also decides conditional branches. It checks a 4-bit condition code against the stored flags and drives a taken signal. It also forms the branch destination from the current program counter and a signed displacement. A short branch uses an 8-bit displacement and a long branch uses a 16-bit one. The branch outputs are combinational, so a branch that follows a flag-setting operation sees the flags from the cycle after the update.

Top module: `cond_flag_unit`

## Requirements
- R1: While `rst_n` is low, all four flags read 0. Reset is asynchronous.
- R2: The flags keep their value across a clock edge when `upd_en` is 0. They also keep it when `op_class` is 7, which is reserved.
- R3: For the logic class (`op_class` 3), Z is set when the result is zero and N is taken from the sign bit. The result is truncated to the selected size, and the sign bit is bit 7 for byte or bit 15 for word. V is cleared and C keeps its value.
- R4: For add (`op_class` 0), C is set when the unsigned sum of the size-masked operands exceeds the size mask. V is set when both operands have the same sign and the result sign differs from it. Z and N follow the R3 rule.
- R5: For subtract (`op_class` 1) and compare (`op_class` 2), C is set when the unsigned left operand is less than the right operand. V is set when the operand signs differ and the result sign differs from the left operand. Z and N follow the R3 rule.
- R6: For shift left (`op_class` 4), C takes the old sign bit of `lhs`. For shift right (`op_class` 5), C takes the old bit 0 of `lhs`. In both cases Z, N and V follow the R3 rule applied to `result`.
- R7: For bit test (`op_class` 6), Z is set to the inverse of bit `bit_sel` of `lhs`. The index is masked to 3 bits for byte size and 4 bits for word size. N, C and V keep their values.
- R8: Condition codes 0 to 7 make `taken` equal to the following, in order:
  - 0: 1
  - 1: 0
  - 2: !C & !Z
  - 3: C | Z
  - 4: !C
  - 5: C
  - 6: !Z
  - 7: Z
- R9: Condition codes 8 to 15 make `taken` equal to the following, in order:
  - 8: !V
  - 9: V
  - 10: !N
  - 11: N
  - 12: N==V
  - 13: N!=V
  - 14: !Z & (N==V)
  - 15: Z | (N!=V)
- R10: When `long_br` is 0, `target` is `pc + 2 + sext(disp[7:0])`, modulo 2^16.
- R11: When `long_br` is 1, `target` is `pc + 3 + sext(disp[15:0])`, modulo 2^16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_en | input | 1 | Flag update strobe |
| op_class | input | 3 | Operation class (0 add, 1 sub, 2 cmp, 3 logic, 4 shl, 5 shr, 6 bit test, 7 reserved) |
| word_sz | input | 1 | 1 = word (16-bit), 0 = byte |
| lhs | input | 16 | Left operand, or the value before a shift or bit test |
| rhs | input | 16 | Right operand |
| result | input | 16 | Result produced by the datapath |
| bit_sel | input | 4 | Bit index for bit test |
| cond_code | input | 4 | Branch condition code |
| pc | input | 16 | Address of the branch instruction |
| disp | input | 16 | Displacement (low byte only for a short branch) |
| long_br | input | 1 | Selects the 16-bit displacement form |
| flag_z | output | 1 | Zero flag |
| flag_n | output | 1 | Negative flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| taken | output | 1 | Condition holds |
| target | output | 16 | Branch destination |

## Verification
A corrupted stored flag appears on the flag ports one cycle after the faulty update. It also appears in the same cycle as a wrong `taken` value for every condition code that reads that flag. A byte/word mix-up shows up directly in C, N or Z as soon as operands have different bytes, or when bit 7 and bit 15 disagree. The reference model follows every update, so a wrong state is seen at the first sampled edge after it appears. Target errors are purely combinational and appear within the same cycle.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
  localparam int DATA_W = 16;
  localparam int BYTE_W = 8;
  localparam int CC_W   = 4;

  typedef enum logic [2:0] {
    OPC_ADD   = 3'd0,
    OPC_SUB   = 3'd1,
    OPC_CMP   = 3'd2,
    OPC_LOGIC = 3'd3,
    OPC_SHL   = 3'd4,
    OPC_SHR   = 3'd5,
    OPC_BTST  = 3'd6,
    OPC_RSVD  = 3'd7
  } op_class_e;

  typedef struct packed {
    logic z;
    logic n;
    logic c;
    logic v;
  } flags_t;
endpackage

// File: rtl/ccu_flag_calc.sv
module ccu_flag_calc
  import ccu_pkg::*;
#(
  parameter int DW  = DATA_W,
  parameter int BW  = BYTE_W,
  localparam int IW = $clog2(DW)
) (
  input  op_class_e       op,
  input  logic            word_sz,
  input  logic [DW-1:0]   lhs,
  input  logic [DW-1:0]   rhs,
  input  logic [DW-1:0]   result,
  input  logic [IW-1:0]   bit_sel,
  input  flags_t          cur,
  output flags_t          nxt
);
  localparam int BIW = $clog2(BW);

  logic [DW-1:0] size_mask;
  logic [DW-1:0] lm, rm, resm;
  logic          sgn_l, sgn_r, sgn_res;
  logic          res_zero;
  logic [DW:0]   sum_w;
  logic          add_carry, add_ovf, sub_borrow, sub_ovf;
  logic [IW-1:0] bit_idx;

  assign size_mask = word_sz ? {DW{1'b1}} : {{(DW-BW){1'b0}}, {BW{1'b1}}};
  assign lm   = lhs & size_mask;
  assign rm   = rhs & size_mask;
  assign resm = result & size_mask;

  assign sgn_l   = word_sz ? lhs[DW-1]    : lhs[BW-1];
  assign sgn_r   = word_sz ? rhs[DW-1]    : rhs[BW-1];
  assign sgn_res = word_sz ? result[DW-1] : result[BW-1];
  assign res_zero = (resm == '0);

  // R4: carry out of the selected width
  assign sum_w     = {1'b0, lm} + {1'b0, rm};
  assign add_carry = word_sz ? sum_w[DW] : sum_w[BW];
  assign add_ovf   = (sgn_l == sgn_r) && (sgn_res != sgn_l);
  // R5: unsigned borrow and signed overflow
  assign sub_borrow = (lm < rm);
  assign sub_ovf    = (sgn_l != sgn_r) && (sgn_res != sgn_l);

  // R7: index masked to the operand width
  assign bit_idx = word_sz ? bit_sel : {{(IW-BIW){1'b0}}, bit_sel[BIW-1:0]};

  always_comb begin
    nxt = cur;
    unique case (op)
      OPC_ADD: begin
        nxt.z = res_zero;
        nxt.n = sgn_res;
        nxt.c = add_carry;
        nxt.v = add_ovf;
      end
      OPC_SUB, OPC_CMP: begin
        nxt.z = res_zero;
        nxt.n = sgn_res;
        nxt.c = sub_borrow;
        nxt.v = sub_ovf;
      end
      OPC_LOGIC: begin
        nxt.z = res_zero;
        nxt.n = sgn_res;
        nxt.v = 1'b0;
      end
      OPC_SHL: begin
        nxt.z = res_zero;
        nxt.n = sgn_res;
        nxt.c = sgn_l;
        nxt.v = 1'b0;
      end
      OPC_SHR: begin
        nxt.z = res_zero;
        nxt.n = sgn_res;
        nxt.c = lhs[0];
        nxt.v = 1'b0;
      end
      OPC_BTST: begin
        nxt.z = ~lhs[bit_idx];
      end
      default: nxt = cur;
    endcase
  end
endmodule

// File: rtl/ccu_cond_eval.sv
module ccu_cond_eval
  import ccu_pkg::*;
#(
  parameter int CW  = CC_W,
  localparam int NC = 1 << CW
) (
  input  flags_t        flg,
  input  logic [CW-1:0] cond_code,
  output logic          taken
);
  logic [NC-1:0] cond_vec;
  logic          nv_eq;

  assign nv_eq = (flg.n == flg.v);

  // R8 / R9: even codes are the complement of the following odd code pairs
  always_comb begin
    cond_vec     = '0;
    cond_vec[0]  = 1'b1;
    cond_vec[1]  = 1'b0;
    cond_vec[2]  = ~flg.c & ~flg.z;
    cond_vec[3]  = flg.c | flg.z;
    cond_vec[4]  = ~flg.c;
    cond_vec[5]  = flg.c;
    cond_vec[6]  = ~flg.z;
    cond_vec[7]  = flg.z;
    cond_vec[8]  = ~flg.v;
    cond_vec[9]  = flg.v;
    cond_vec[10] = ~flg.n;
    cond_vec[11] = flg.n;
    cond_vec[12] = nv_eq;
    cond_vec[13] = ~nv_eq;
    cond_vec[14] = ~flg.z & nv_eq;
    cond_vec[15] = flg.z | ~nv_eq;
  end

  assign taken = cond_vec[cond_code];
endmodule

// File: rtl/ccu_target_gen.sv
module ccu_target_gen
  import ccu_pkg::*;
#(
  parameter int AW        = DATA_W,
  parameter int SDW       = BYTE_W,
  parameter int SHORT_LEN = 2,
  parameter int LONG_LEN  = 3
) (
  input  logic [AW-1:0] pc,
  input  logic [AW-1:0] disp,
  input  logic          long_br,
  output logic [AW-1:0] target
);
  logic [AW-1:0] ofs;
  logic [AW-1:0] ilen;

  // R10 / R11
  assign ofs    = long_br ? disp : {{(AW-SDW){disp[SDW-1]}}, disp[SDW-1:0]};
  assign ilen   = long_br ? AW'(LONG_LEN) : AW'(SHORT_LEN);
  assign target = pc + ilen + ofs;
endmodule

// File: rtl/cond_flag_unit.sv
module cond_flag_unit
  import ccu_pkg::*;
#(
  parameter int DW = DATA_W,
  parameter int CW = CC_W,
  localparam int IW = $clog2(DW)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          upd_en,
  input  logic [2:0]    op_class,
  input  logic          word_sz,
  input  logic [DW-1:0] lhs,
  input  logic [DW-1:0] rhs,
  input  logic [DW-1:0] result,
  input  logic [IW-1:0] bit_sel,
  input  logic [CW-1:0] cond_code,
  input  logic [DW-1:0] pc,
  input  logic [DW-1:0] disp,
  input  logic          long_br,
  output logic          flag_z,
  output logic          flag_n,
  output logic          flag_c,
  output logic          flag_v,
  output logic          taken,
  output logic [DW-1:0] target
);
  flags_t flags_q, flags_calc, flags_d;

  ccu_flag_calc #(.DW(DW), .BW(BYTE_W)) u_calc (
    .op      (op_class_e'(op_class)),
    .word_sz (word_sz),
    .lhs     (lhs),
    .rhs     (rhs),
    .result  (result),
    .bit_sel (bit_sel),
    .cur     (flags_q),
    .nxt     (flags_calc)
  );

  // R2: written-out clock enable
  always_comb begin
    flags_d = flags_q;
    if (upd_en) flags_d = flags_calc;
  end

  // R1: asynchronous clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  ccu_cond_eval #(.CW(CW)) u_cond (
    .flg       (flags_q),
    .cond_code (cond_code),
    .taken     (taken)
  );

  ccu_target_gen #(.AW(DW), .SDW(BYTE_W)) u_tgt (
    .pc      (pc),
    .disp    (disp),
    .long_br (long_br),
    .target  (target)
  );

  assign flag_z = flags_q.z;
  assign flag_n = flags_q.n;
  assign flag_c = flags_q.c;
  assign flag_v = flags_q.v;

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !upd_en |=> $stable(flags_q)); // R2
  AST_LOGIC_CLEARS_V: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && op_class == 3'd3) |=> (!flag_v && $stable(flag_c))); // R3
  AST_BTST_KEEPS_NCV: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && op_class == 3'd6) |=> ($stable(flag_n) && $stable(flag_c) && $stable(flag_v))); // R7
  AST_SHL_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && op_class == 3'd4 && word_sz) |=> (flag_c == $past(lhs[DW-1]))); // R6
  AST_NEVER_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_code == CW'(1)) |-> !taken); // R8
  AST_NV_PAIR: assert property (@(posedge clk) disable iff (!rst_n)
    (cond_code == CW'(12)) |-> (taken == (flag_n == flag_v))); // R9
endmodule

// File: tb/cond_flag_unit_tb.sv
module cond_flag_unit_tb;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        upd_en, word_sz, long_br;
  logic [2:0]  op_class;
  logic [15:0] lhs, rhs, result, pc, disp, target;
  logic [3:0]  bit_sel, cond_code;
  logic        flag_z, flag_n, flag_c, flag_v, taken;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit mz, mn, mc, mv;

  always #(PERIOD/2) clk = ~clk;

  cond_flag_unit u_dut (
    .clk(clk), .rst_n(rst_n), .upd_en(upd_en), .op_class(op_class),
    .word_sz(word_sz), .lhs(lhs), .rhs(rhs), .result(result),
    .bit_sel(bit_sel), .cond_code(cond_code), .pc(pc), .disp(disp),
    .long_br(long_br), .flag_z(flag_z), .flag_n(flag_n), .flag_c(flag_c),
    .flag_v(flag_v), .taken(taken), .target(target)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic string op_tag(input int op);
    case (op)
      0:       return "R4";
      1, 2:    return "R5";
      3:       return "R3";
      4, 5:    return "R6";
      6:       return "R7";
      default: return "R2";
    endcase
  endfunction

  function automatic bit ref_cond(input int cc);
    case (cc)
      0:  return 1;
      1:  return 0;
      2:  return !mc && !mz;
      3:  return mc || mz;
      4:  return !mc;
      5:  return mc;
      6:  return !mz;
      7:  return mz;
      8:  return !mv;
      9:  return mv;
      10: return !mn;
      11: return mn;
      12: return mn == mv;
      13: return mn != mv;
      14: return !mz && (mn == mv);
      default: return mz || (mn != mv);
    endcase
  endfunction

  task automatic step(input int op, input bit w, input int l, input int r, input int res,
                      input int bs, input int cc, input int p, input int d,
                      input bit lg, input bit en);
    int mask, sb, lm, rm, rs, sext, exp_t, idx;
    @(negedge clk);
    op_class = op[2:0]; word_sz = w; lhs = l[15:0]; rhs = r[15:0];
    result = res[15:0]; bit_sel = bs[3:0]; cond_code = cc[3:0];
    pc = p[15:0]; disp = d[15:0]; long_br = lg; upd_en = en;
    #1;
    chk((cc < 8) ? "R8" : "R9", {31'd0, taken}, {31'd0, ref_cond(cc)});
    if (lg) sext = (d & 16'h8000) ? (d & 16'hFFFF) - 65536 : (d & 16'hFFFF);
    else    sext = (d & 8'h80) ? (d & 8'hFF) - 256 : (d & 8'hFF);
    exp_t = (p + (lg ? 3 : 2) + sext) & 16'hFFFF;
    chk(lg ? "R11" : "R10", {16'd0, target}, exp_t);
    mask = w ? 32'hFFFF : 32'hFF;
    sb   = w ? 32'h8000 : 32'h80;
    lm = l & mask; rm = r & mask; rs = res & mask;
    if (en && op < 7) begin
      if (op != 6) begin
        mz = (rs == 0);
        mn = (rs & sb) != 0;
      end
      case (op)
        0: begin mc = (lm + rm) > mask; mv = ((~(lm ^ rm)) & (lm ^ rs) & sb) != 0; end
        1, 2: begin mc = lm < rm; mv = ((lm ^ rm) & (lm ^ rs) & sb) != 0; end
        3: mv = 0;
        4: begin mc = (lm & sb) != 0; mv = 0; end
        5: begin mc = (l & 1) != 0; mv = 0; end
        6: begin
          idx = w ? (bs & 15) : (bs & 7);
          mz = ((l >> idx) & 1) == 0;
        end
        default: ;
      endcase
    end
    @(posedge clk);
    #1;
    chk((en && op < 7) ? op_tag(op) : "R2",
        {28'd0, flag_z, flag_n, flag_c, flag_v}, {28'd0, mz, mn, mc, mv});
  endtask

  function automatic int make_res(input int op, input int l, input int r, input bit w);
    case (op)
      0: return l + r;
      1, 2: return l - r;
      3: return l ^ r;
      4: return l << 1;
      5: return w ? ((l & 16'hFFFF) >> 1) : ((l & 8'hFF) >> 1);
      default: return l;
    endcase
  endfunction

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual hung expected finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; upd_en = 0; op_class = 0; word_sz = 0; lhs = 0; rhs = 0;
    result = 16'hFFFF; bit_sel = 0; cond_code = 0; pc = 0; disp = 0; long_br = 0;
    mz = 0; mn = 0; mc = 0; mv = 0;
    repeat (3) @(posedge clk);
    upd_en = 1;
    @(negedge clk);
    chk("R1", {28'd0, flag_z, flag_n, flag_c, flag_v}, 32'd0);
    rst_n = 1'b1;
    upd_en = 0;
    // directed corners
    step(0, 0, 'h7F, 'h01, 'h80, 0, 9, 'h1000, 'h80, 0, 1);     // R4 byte overflow
    step(0, 1, 'hFFFF, 'h0001, 'h0000, 0, 7, 'hFFFE, 'h0001, 1, 1); // R4 word carry, R11 wrap
    step(1, 0, 'h00, 'h01, 'hFF, 0, 5, 'h0000, 'hFE, 0, 1);     // R5 borrow, R10 wrap
    step(2, 1, 'h8000, 'h0001, 'h7FFF, 0, 13, 'h1234, 'h8000, 1, 1); // R5 overflow
    step(3, 0, 'h55, 'h55, 'h100, 0, 3, 'h0010, 'h7F, 0, 1);    // R3 byte zero ignores bit 8
    step(4, 0, 'h80, 0, 'h100, 0, 5, 0, 0, 0, 1);               // R6 shl carry
    step(5, 1, 'h0001, 0, 'h0000, 0, 15, 0, 0, 1, 1);           // R6 shr carry
    step(6, 0, 'h0080, 0, 0, 15, 6, 0, 0, 0, 1);                // R7 index masked to 7
    step(6, 1, 'h0080, 0, 0, 15, 6, 0, 0, 0, 1);                // R7 word bit 15
    step(7, 1, 'h1234, 'h1, 0, 0, 14, 0, 0, 0, 1);              // R2 reserved
    step(0, 1, 'h1234, 'h1, 0, 0, 12, 0, 0, 0, 0);              // R2 no strobe
    for (int i = 0; i < 4000; i++) begin
      int op, l, r, res;
      bit w;
      op = ($urandom % 10 == 0) ? 7 : int'($urandom % 7);
      w = $urandom[0];
      l = int'($urandom & 32'hFFFF);
      r = ($urandom % 4 == 0) ? l : int'($urandom & 32'hFFFF);
      res = ($urandom % 6 == 0) ? int'($urandom & 32'hFFFF) : make_res(op, l, r, w);
      if ($urandom % 5 == 0) res = res & 32'hFF00;
      step(op, w, l, r, res, int'($urandom % 16), int'($urandom % 16),
           int'($urandom & 32'hFFFF), int'($urandom & 32'hFFFF), $urandom[1],
           ($urandom % 4) != 0);
    end
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule